// File: doc/BRIEF.md
# HDLC Controller Interrupt Aggregator

This block gathers event indications from an HDLC transmitter, an HDLC receiver and their two FIFOs. It drives one active-low interrupt line toward the host. Events that are enabled in an 8-bit mask/control register are latched into a clear-on-read status register. The first enabled event pulls the interrupt line low. The line then stays low until the host reads the status register. Events that arrive in the meantime are only recorded, and the host collects them all with that one read.

A transparent-mode input changes which sources count. In transparent mode the frame-oriented sources are dropped: underrun, receive end-of-frame and receiver idle. Transmit-done also changes meaning. It becomes the moment the transmit FIFO goes completely empty, instead of the end of a closing flag or abort. The two FIFO threshold conditions arrive as levels and are edge-detected inside the block. The top bit of the mask register does not enable any event. It drives a force-bad-CRC control output to the transmitter. A small synchronous register port with a 4-bit address and 8-bit data gives the host access.

Top module: `hdlc_irq_agg`

## Requirements
- R1: A write strobe at address 0x2 loads the mask register from the write data. A read at address 0x2 returns it. Bit positions: 0 transmit-done, 1 transmit-empty threshold, 2 underrun, 3 receive-full threshold, 4 receive end-of-frame, 5 receive overrun, 6 receiver idle, 7 force-bad-CRC.
- R2: After reset the mask register reads 0, the status register reads 0, `irq_no` is 1 and `bad_crc_o` is 0.
- R3: An event whose enable bit is 1 sets its status bit and drives `irq_no` low from the clock edge that samples it. An event whose enable bit is 0 is neither recorded nor able to drive `irq_no` low.
- R4: Once `irq_no` is low, it stays low until a status read. Enabled events that arrive in that time set their status bits without any new transition.
- R5: A read strobe at address 0x3 returns the latched status bits in the R1 positions, with bit 7 reading 0. The same edge clears those bits and releases `irq_no`. An enabled event sampled on that same edge is kept: its bit reads back on the next read, and `irq_no` stays low.
- R6: With `transparent_i` = 0, transmit-done is the `tx_frame_end_i` pulse, and `tx_fifo_void_i` has no effect. With `transparent_i` = 1, transmit-done is the rising edge of `tx_fifo_void_i`, and `tx_frame_end_i` has no effect.
- R7: With `transparent_i` = 1, the underrun, receive end-of-frame and receiver-idle inputs are ignored.
- R8: The transmit-empty and receive-full threshold levels raise an event only on a 0-to-1 change. A level held high yields one event.
- R9: `bad_crc_o` equals mask bit 7. It stays 1 until a write clears that bit.
- R10: Reads at any address other than 0x2 or 0x3 return 0. Writes to any address other than 0x2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| transparent_i | input | 1 | 1 selects transparent mode |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_wr_i | input | 1 | Single-cycle write strobe |
| host_rd_i | input | 1 | Single-cycle read strobe |
| host_rdata_o | output | 8 | Read data, combinational from the address |
| tx_frame_end_i | input | 1 | Pulse: last bit of a closing flag or abort sent |
| tx_underrun_i | input | 1 | Pulse: transmit FIFO underrun |
| rx_eof_i | input | 1 | Pulse: receive end-of-frame |
| rx_overrun_i | input | 1 | Pulse: receive FIFO overrun |
| rx_idle_i | input | 1 | Pulse: receiver entered idle |
| tx_fifo_void_i | input | 1 | Level: transmit FIFO completely empty |
| tx_at_empty_lvl_i | input | 1 | Level: transmit fill at or below the empty threshold |
| rx_at_full_lvl_i | input | 1 | Level: receive fill at or above the full threshold |
| irq_no | output | 1 | Registered interrupt, active low |
| bad_crc_o | output | 1 | Force-bad-CRC control to the transmitter |

## Verification
A corrupted status bit shows up in the data of the next status read. A lost or spurious interrupt state shows up on `irq_no` one edge after the event or the read that should have changed it. A stale threshold history would produce a repeated or missing event, which becomes visible at the next crossing, when the line and the status read disagree with the level sequence the bench drove. A wrong mode qualification appears as soon as a suppressed source pulses with its enable set.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int ADDR_W  = 4;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 7;
  localparam int NUM_LVL = 3;

  localparam logic [ADDR_W-1:0] MASK_ADDR = 4'h2;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 4'h3;

  // event bit positions, shared by mask and status
  localparam int B_TXDONE  = 0;
  localparam int B_TXLOW   = 1;
  localparam int B_UNDER   = 2;
  localparam int B_RXHIGH  = 3;
  localparam int B_EOF     = 4;
  localparam int B_OVER    = 5;
  localparam int B_IDLE    = 6;
  localparam int B_BADCRC  = 7;

  // level input slots
  localparam int L_TXVOID = 0;
  localparam int L_TXLOW  = 1;
  localparam int L_RXHIGH = 2;

  typedef logic [REG_W-1:0]   reg_t;
  typedef logic [NUM_SRC-1:0] src_t;
  typedef logic [NUM_LVL-1:0] lvl_t;
endpackage

// File: rtl/hdlc_irq_src.sv
module hdlc_irq_src
  import hdlc_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic transparent_i,
  input  logic tx_frame_end_i,
  input  logic tx_underrun_i,
  input  logic rx_eof_i,
  input  logic rx_overrun_i,
  input  logic rx_idle_i,
  input  lvl_t lvl_i,
  output src_t src_o
);
  lvl_t lvl_q;
  lvl_t rise;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[i] <= 1'b0;
      else         lvl_q[i] <= lvl_i[i];
    end
    assign rise[i] = lvl_i[i] & ~lvl_q[i];
  end

  always_comb begin
    src_o           = '0;
    src_o[B_TXDONE] = transparent_i ? rise[L_TXVOID] : tx_frame_end_i;
    src_o[B_TXLOW]  = rise[L_TXLOW];
    src_o[B_UNDER]  = ~transparent_i & tx_underrun_i;
    src_o[B_RXHIGH] = rise[L_RXHIGH];
    src_o[B_EOF]    = ~transparent_i & rx_eof_i;
    src_o[B_OVER]   = rx_overrun_i;
    src_o[B_IDLE]   = ~transparent_i & rx_idle_i;
  end

  // R7: frame-only sources silent in transparent mode
  a_r7_transp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transparent_i |-> !(src_o[B_UNDER] || src_o[B_EOF] || src_o[B_IDLE]));

  // R8: a held level cannot fire on consecutive cycles
  a_r8_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o[B_RXHIGH] |=> !src_o[B_RXHIGH]);
endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
  import hdlc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  reg_t              host_wdata_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  src_t              status_i,
  output reg_t              host_rdata_o,
  output reg_t              mask_o,
  output logic              rd_stat_o
);
  reg_t mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   mask_q <= '0;
    else if (host_wr_i && host_addr_i == MASK_ADDR) mask_q <= host_wdata_i;
  end

  always_comb begin
    unique case (host_addr_i)
      MASK_ADDR: host_rdata_o = mask_q;
      STAT_ADDR: host_rdata_o = {1'b0, status_i};
      default:   host_rdata_o = '0;
    endcase
  end

  assign mask_o    = mask_q;
  assign rd_stat_o = host_rd_i && (host_addr_i == STAT_ADDR);

  // R2: mask cleared while in reset
  always @(posedge clk_i) begin
    if (!rst_ni) a_r2_mask_reset: assert (mask_q == '0);
  end

  // R1: non-mask writes leave mask alone
  a_r1_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_wr_i && host_addr_i == MASK_ADDR) |=> $stable(mask_q));

  // R5: status bit 7 always reads 0
  a_r5_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i == STAT_ADDR) |-> !host_rdata_o[B_BADCRC]);
endmodule

// File: rtl/hdlc_irq_stat.sv
module hdlc_irq_stat
  import hdlc_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_t src_i,
  input  src_t enable_i,
  input  logic rd_stat_i,
  output src_t status_o,
  output logic irq_no
);
  src_t ev;
  src_t status_q;
  logic irq_q;

  assign ev = src_i & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      // read clears, same-edge events survive
      status_q <= (rd_stat_i ? '0 : status_q) | ev;
      irq_q    <= (rd_stat_i ? 1'b0 : irq_q) | (|ev);
    end
  end

  assign status_o = status_q;
  assign irq_no   = ~irq_q;

  // R3: enabled event asserts line next edge
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> irq_q);

  // R4: line held until a status read
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !rd_stat_i) |=> irq_q);

  // R5: quiet read releases the line
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !(|ev)) |=> !irq_q);

  // R4: nothing recorded without an active line
  a_r4_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_q) |-> irq_q);
endmodule

// File: rtl/hdlc_irq_agg.sv
module hdlc_irq_agg
  import hdlc_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        transparent_i,
  input  logic [3:0]  host_addr_i,
  input  logic [7:0]  host_wdata_i,
  input  logic        host_wr_i,
  input  logic        host_rd_i,
  output logic [7:0]  host_rdata_o,
  input  logic        tx_frame_end_i,
  input  logic        tx_underrun_i,
  input  logic        rx_eof_i,
  input  logic        rx_overrun_i,
  input  logic        rx_idle_i,
  input  logic        tx_fifo_void_i,
  input  logic        tx_at_empty_lvl_i,
  input  logic        rx_at_full_lvl_i,
  output logic        irq_no,
  output logic        bad_crc_o
);
  src_t src;
  src_t status;
  reg_t mask;
  lvl_t lvl;
  logic rd_stat;

  always_comb begin
    lvl           = '0;
    lvl[L_TXVOID] = tx_fifo_void_i;
    lvl[L_TXLOW]  = tx_at_empty_lvl_i;
    lvl[L_RXHIGH] = rx_at_full_lvl_i;
  end

  hdlc_irq_src u_src (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .transparent_i  (transparent_i),
    .tx_frame_end_i (tx_frame_end_i),
    .tx_underrun_i  (tx_underrun_i),
    .rx_eof_i       (rx_eof_i),
    .rx_overrun_i   (rx_overrun_i),
    .rx_idle_i      (rx_idle_i),
    .lvl_i          (lvl),
    .src_o          (src)
  );

  hdlc_irq_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .status_i     (status),
    .host_rdata_o (host_rdata_o),
    .mask_o       (mask),
    .rd_stat_o    (rd_stat)
  );

  hdlc_irq_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src),
    .enable_i  (mask[NUM_SRC-1:0]),
    .rd_stat_i (rd_stat),
    .status_o  (status),
    .irq_no    (irq_no)
  );

  assign bad_crc_o = mask[B_BADCRC];

  // R9: control output tracks mask bit 7
  a_r9_badcrc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_crc_o == host_rdata_o[B_BADCRC] || host_addr_i != MASK_ADDR);
endmodule

// File: tb/hdlc_irq_agg_tb.sv
`timescale 1ns/1ps
module hdlc_irq_agg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       transp = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       fend = 0, under = 0, eof = 0, over = 0, idle = 0;
  logic       tvoid = 0, tlow = 0, rhigh = 0;
  logic       irq_n, badcrc;

  always #2.5 clk = ~clk;

  hdlc_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .transparent_i(transp),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_wr_i(wr), .host_rd_i(rd),
    .host_rdata_o(rdata),
    .tx_frame_end_i(fend), .tx_underrun_i(under), .rx_eof_i(eof),
    .rx_overrun_i(over), .rx_idle_i(idle),
    .tx_fifo_void_i(tvoid), .tx_at_empty_lvl_i(tlow), .rx_at_full_lvl_i(rhigh),
    .irq_no(irq_n), .bad_crc_o(badcrc)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R2";
  bit finished = 0;

  // reference state
  logic [7:0] m_mask = '0;
  logic [6:0] m_stat = '0;
  logic       m_irq  = 1'b0;
  logic [2:0] m_prev = '0;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [3:0] a);
    if (a == 4'h2) return m_mask;
    if (a == 4'h3) return {1'b0, m_stat};
    return 8'h00;
  endfunction

  function automatic logic [6:0] exp_src(input logic t, input logic [2:0] lv, input logic [2:0] pv);
    logic [2:0] r;
    logic [6:0] s;
    r = lv & ~pv;
    s = '0;
    s[0] = t ? r[0] : fend;
    s[1] = r[1];
    s[2] = !t && under;
    s[3] = r[2];
    s[4] = !t && eof;
    s[5] = over;
    s[6] = !t && idle;
    return s;
  endfunction

  // one clock; inputs already set at a negedge
  task automatic step();
    logic [6:0] ev;
    logic [2:0] lv;
    logic       rds;
    #1;
    if (rd) chk("rdata", rdata, exp_rdata(addr));
    lv  = {rhigh, tlow, tvoid};
    ev  = exp_src(transp, lv, m_prev) & m_mask[6:0];
    rds = rd && addr == 4'h3;
    @(posedge clk);
    m_prev = lv;
    m_stat = (rds ? 7'h0 : m_stat) | ev;
    m_irq  = (rds ? 1'b0 : m_irq) | (|ev);
    if (wr && addr == 4'h2) m_mask = wdata;
    #1;
    chk("irq_no", {7'h0, irq_n}, {7'h0, ~m_irq});
    chk("bad_crc_o", {7'h0, badcrc}, {7'h0, m_mask[7]});
    @(negedge clk);
    wr = 0; rd = 0; fend = 0; under = 0; eof = 0; over = 0; idle = 0;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1; step();
  endtask
  task automatic do_rd(input logic [3:0] a);
    addr = a; rd = 1; step();
  endtask
  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int tx_cnt, rx_cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    cur_req = "R2";
    chk("irq_no in reset", {7'h0, irq_n}, 8'h01);
    rst_n = 1;
    idle_n(2);
    do_rd(4'h2);
    do_rd(4'h3);

    cur_req = "R1";
    do_wr(4'h2, 8'h5A); do_rd(4'h2);
    do_wr(4'h2, 8'h00); do_rd(4'h2);

    cur_req = "R10";
    do_wr(4'h9, 8'hFF); do_rd(4'h2); do_rd(4'h9); do_rd(4'hF);

    cur_req = "R9";
    do_wr(4'h2, 8'h80); idle_n(4); do_wr(4'h2, 8'h00); idle_n(2);

    cur_req = "R3";
    do_wr(4'h2, 8'h7E);
    fend = 1; step(); idle_n(1); do_rd(4'h3);  // masked: no irq, status 0
    do_wr(4'h2, 8'h7F);
    fend = 1; step(); idle_n(1);

    cur_req = "R4";
    over = 1; step(); idle = 1; step(); idle_n(2);

    cur_req = "R5";
    do_rd(4'h3);                       // expect 0x61
    idle_n(1);
    addr = 4'h3; rd = 1; eof = 1; step();  // event on read edge kept
    idle_n(1); do_rd(4'h3); idle_n(1);

    cur_req = "R6";
    transp = 1;
    fend = 1; step(); idle_n(1); do_rd(4'h3);
    tvoid = 1; step(); idle_n(3); do_rd(4'h3);
    tvoid = 0; step();
    transp = 0;
    tvoid = 1; step(); idle_n(1); do_rd(4'h3);
    tvoid = 0; step();

    cur_req = "R7";
    transp = 1;
    under = 1; eof = 1; idle = 1; step(); idle_n(1); do_rd(4'h3);
    over = 1; step(); do_rd(4'h3);
    transp = 0; step();

    cur_req = "R8";
    rhigh = 1; step(); idle_n(1); do_rd(4'h3); idle_n(5); do_rd(4'h3);
    rhigh = 0; step(); rhigh = 1; step(); do_rd(4'h3); rhigh = 0;
    tlow = 1; idle_n(4); do_rd(4'h3); tlow = 0; step();

    cur_req = "R5";
    tx_cnt = 8; rx_cnt = 3;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) tx_cnt += ($urandom_range(0, 1) == 0) ? -1 : 1;
      if ($urandom_range(0, 3) == 0) rx_cnt += ($urandom_range(0, 1) == 0) ? -1 : 1;
      if (tx_cnt < 0) tx_cnt = 0; if (tx_cnt > 16) tx_cnt = 16;
      if (rx_cnt < 0) rx_cnt = 0; if (rx_cnt > 16) rx_cnt = 16;
      tvoid = (tx_cnt == 0);
      tlow  = (tx_cnt <= 4);
      rhigh = (rx_cnt >= 12);
      fend  = ($urandom_range(0, 9) == 0);
      under = ($urandom_range(0, 19) == 0);
      eof   = ($urandom_range(0, 9) == 0);
      over  = ($urandom_range(0, 19) == 0);
      idle  = ($urandom_range(0, 14) == 0);
      if ($urandom_range(0, 199) == 0) transp = ~transp;
      case ($urandom_range(0, 15))
        0, 1: begin addr = 4'h3; rd = 1; end
        2:    begin addr = 4'h2; rd = 1; end
        3:    begin addr = 4'h2; wdata = 8'($urandom); wr = 1; end
        4:    begin addr = 4'($urandom); rd = 1; wdata = 8'($urandom); wr = ($urandom_range(0, 1) == 1); end
        default: ;
      endcase
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule